// File: doc/BRIEF.md
# Reloading Prescaler with Event Counter

This block divides a fixed-rate tick enable by a programmable amount and counts how many division periods have elapsed. A down-counting prescaler moves one step on every tick. When a tick arrives while the prescaler already holds zero, the prescaler takes a fresh value from a reload register, and a 32-bit event counter advances by one on that same tick. The reload therefore happens one tick after zero is reached, not at zero. A full period thus lasts the reload value plus one tick.

Software can load each of the three registers directly: the reload value, the live prescaler and the event counter. It can also read each of them at any time on a dedicated value port. A write wins over the tick update of the register it targets in the same cycle. Counting then carries on from the written state at the next tick.

A reload value of zero makes the prescaler stay at zero once it gets there, so the event counter then advances on every tick. The tick enable is produced elsewhere, from a prescale clock whose nominal rate is a parameter with a default of 20 MHz. Address decoding also lives outside the block.

Top module: `tick_prescale_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the reload value, the prescaler and the event counter all become zero, and each reads zero afterwards.
- R2: On a clock edge with `tick_en` high, no prescaler load, and a nonzero prescaler, the prescaler decreases by exactly one. With `tick_en` low and no prescaler load, the prescaler keeps its value.
- R3: On a clock edge with `tick_en` high and a prescaler of zero, the prescaler takes the reload value held before that edge. The event counter advances by one at the same edge, unless it is being loaded.
- R4: With a reload value of zero, the prescaler stays at zero after reaching it. From then on the event counter advances on every tick.
- R5: A prescaler load (`presc_ld` high) sets the prescaler to `presc_ld_val` at that edge, even when a tick arrives in the same cycle. A tick at a prescaler of zero still advances the event counter in that cycle.
- R6: An event counter load (`evt_ld` high) sets the counter to `evt_ld_val` at that edge, taking priority over an increment due in the same cycle.
- R7: A reload load (`reload_ld` high) replaces the reload value at that edge. It leaves the current prescaler value untouched and takes effect at the next reload.
- R8: The event counter wraps from 0xFFFFFFFF to 0 on an increment, and no other output changes because of the wrap.
- R9: Take a reload value of 5 and a prescaler of 7. Over ticks 1 to 14, the prescaler reads 6,5,4,3,2,1,0,5,4,3,2,1,0,5, and the event counter advances only at ticks 8 and 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle prescale tick enable |
| reload_ld | input | 1 | Load strobe for the reload value |
| reload_ld_val | input | PRESC_W | Data for the reload value |
| presc_ld | input | 1 | Load strobe for the prescaler |
| presc_ld_val | input | PRESC_W | Data for the prescaler |
| evt_ld | input | 1 | Load strobe for the event counter |
| evt_ld_val | input | EVT_W | Data for the event counter |
| reload_q | output | PRESC_W | Current reload value |
| presc_q | output | PRESC_W | Current prescaler value |
| evt_q | output | EVT_W | Current event counter value |

## Verification
The bench builds the block with its default parameters: 32-bit prescaler and event counter, and a 20 MHz nominal tick rate. At these widths the counter cannot wrap through counting alone. Loading the counter directly with 0xFFFFFFFF puts the wrap one tick away. Small loaded prescaler values keep every reload boundary, the stuck-at-zero mode and the load-versus-tick collisions within a few dozen cycles.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  // Source chosen for the next prescaler value
  typedef enum logic [1:0] {
    PSRC_HOLD   = 2'd0,
    PSRC_LOAD   = 2'd1,
    PSRC_DEC    = 2'd2,
    PSRC_RELOAD = 2'd3
  } presc_src_e;
endpackage

// File: rtl/tpc_reload_reg.sv
module tpc_reload_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= ld_val;
  end
endmodule

// File: rtl/tpc_presc_down.sv
module tpc_presc_down
  import tpc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] q,
  output logic         period_end
);
  localparam logic [W-1:0] ONE = W'(1);

  presc_src_e src;
  logic       at_zero;

  assign at_zero    = (q == '0);
  // Period completes on the tick that finds the prescaler at zero
  assign period_end = tick & at_zero;

  always_comb begin
    if (ld)           src = PSRC_LOAD;
    else if (!tick)   src = PSRC_HOLD;
    else if (at_zero) src = PSRC_RELOAD;
    else              src = PSRC_DEC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (src)
        PSRC_LOAD:   q <= ld_val;
        PSRC_RELOAD: q <= reload_val;
        PSRC_DEC:    q <= q - ONE;
        default:     q <= q;
      endcase
    end
  end
endmodule

// File: rtl/tpc_evt_count.sv
module tpc_evt_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (inc) q <= q + ONE;   // wraps silently at all-ones
  end
endmodule

// File: rtl/tick_prescale_counter.sv
module tick_prescale_counter #(
  parameter int PRESC_W = 32,
  parameter int EVT_W   = 32,
  parameter int TICK_HZ = 20_000_000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               reload_ld,
  input  logic [PRESC_W-1:0] reload_ld_val,
  input  logic               presc_ld,
  input  logic [PRESC_W-1:0] presc_ld_val,
  input  logic               evt_ld,
  input  logic [EVT_W-1:0]   evt_ld_val,
  output logic [PRESC_W-1:0] reload_q,
  output logic [PRESC_W-1:0] presc_q,
  output logic [EVT_W-1:0]   evt_q
);
  generate
    if (TICK_HZ < 1) begin : g_bad_rate
      $error("TICK_HZ must be positive");
    end
  endgenerate

  logic period_end;

  tpc_reload_reg #(.W(PRESC_W)) u_reload (
    .clk    (clk),
    .rst    (rst),
    .ld     (reload_ld),
    .ld_val (reload_ld_val),
    .q      (reload_q)
  );

  tpc_presc_down #(.W(PRESC_W)) u_presc (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick_en),
    .ld         (presc_ld),
    .ld_val     (presc_ld_val),
    .reload_val (reload_q),
    .q          (presc_q),
    .period_end (period_end)
  );

  tpc_evt_count #(.W(EVT_W)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .inc    (period_end),
    .ld     (evt_ld),
    .ld_val (evt_ld_val),
    .q      (evt_q)
  );
endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int PW = 32,
  parameter int EW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          tick_en,
  input logic          reload_ld,
  input logic [PW-1:0] reload_ld_val,
  input logic          presc_ld,
  input logic [PW-1:0] presc_ld_val,
  input logic          evt_ld,
  input logic [EW-1:0] evt_ld_val,
  input logic [PW-1:0] reload_q,
  input logic [PW-1:0] presc_q,
  input logic [EW-1:0] evt_q
);
  p_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !presc_ld && presc_q != '0) |=> presc_q == $past(presc_q) - PW'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !presc_ld) |=> $stable(presc_q));

  p_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !presc_ld && presc_q == '0) |=> presc_q == $past(reload_q));

  p_evt_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !evt_ld && presc_q == '0) |=> evt_q == $past(evt_q) + EW'(1));

  p_evt_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!evt_ld && !(tick_en && presc_q == '0)) |=> $stable(evt_q));

  p_presc_ld_r5: assert property (@(posedge clk) disable iff (rst)
    presc_ld |=> presc_q == $past(presc_ld_val));

  p_evt_ld_r6: assert property (@(posedge clk) disable iff (rst)
    evt_ld |=> evt_q == $past(evt_ld_val));

  p_reload_ld_r7: assert property (@(posedge clk) disable iff (rst)
    reload_ld |=> reload_q == $past(reload_ld_val));

  p_reload_keep_r7: assert property (@(posedge clk) disable iff (rst)
    !reload_ld |=> $stable(reload_q));
endmodule

bind tick_prescale_counter tpc_checker #(.PW(PRESC_W), .EW(EVT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tick_en       (tick_en),
  .reload_ld     (reload_ld),
  .reload_ld_val (reload_ld_val),
  .presc_ld      (presc_ld),
  .presc_ld_val  (presc_ld_val),
  .evt_ld        (evt_ld),
  .evt_ld_val    (evt_ld_val),
  .reload_q      (reload_q),
  .presc_q       (presc_q),
  .evt_q         (evt_q)
);

// File: tb/tick_prescale_counter_tb_top.sv
module tick_prescale_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        reload_ld = 1'b0;
  logic [31:0] reload_ld_val = '0;
  logic        presc_ld = 1'b0;
  logic [31:0] presc_ld_val = '0;
  logic        evt_ld = 1'b0;
  logic [31:0] evt_ld_val = '0;
  logic [31:0] reload_q, presc_q, evt_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  tick_prescale_counter dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .reload_ld(reload_ld), .reload_ld_val(reload_ld_val),
    .presc_ld(presc_ld), .presc_ld_val(presc_ld_val),
    .evt_ld(evt_ld), .evt_ld_val(evt_ld_val),
    .reload_q(reload_q), .presc_q(presc_q), .evt_q(evt_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One clock edge with the given tick; strobes drop afterwards
  task automatic step(input bit tk);
    tick_en = tk;
    @(posedge clk);
    #1;
    tick_en = 1'b0;
    reload_ld = 1'b0;
    presc_ld = 1'b0;
    evt_ld = 1'b0;
  endtask

  task automatic load_all(input logic [31:0] rl, input logic [31:0] pr, input logic [31:0] ev);
    reload_ld = 1'b1; reload_ld_val = rl;
    presc_ld = 1'b1;  presc_ld_val = pr;
    evt_ld = 1'b1;    evt_ld_val = ev;
    step(1'b0);
  endtask

  task automatic t_reset();
    load_all(32'd9, 32'd4, 32'd33);
    rst = 1'b1;
    step(1'b1);
    rst = 1'b0;
    check("R1 reload", reload_q, 32'd0);
    check("R1 presc", presc_q, 32'd0);
    check("R1 evt", evt_q, 32'd0);
  endtask

  task automatic t_sequence();
    int exp_p[14] = '{6,5,4,3,2,1,0,5,4,3,2,1,0,5};
    int exp_e;
    load_all(32'd5, 32'd7, 32'd0);
    exp_e = 0;
    for (int k = 1; k <= 14; k++) begin
      step(1'b1);
      if (k == 8 || k == 14) exp_e++;
      check($sformatf("R9 presc tick %0d", k), presc_q, 32'(exp_p[k-1]));
      check($sformatf("R9/R3 evt tick %0d", k), evt_q, 32'(exp_e));
    end
  endtask

  task automatic t_hold();
    load_all(32'd5, 32'd3, 32'd2);
    for (int k = 0; k < 4; k++) step(1'b0);
    check("R2 hold presc", presc_q, 32'd3);
    check("R2 hold evt", evt_q, 32'd2);
    step(1'b1);
    check("R2 dec", presc_q, 32'd2);
  endtask

  task automatic t_zero_reload();
    load_all(32'd0, 32'd2, 32'd0);
    step(1'b1); check("R4 presc 1", presc_q, 32'd1);
    step(1'b1); check("R4 presc 0", presc_q, 32'd0);
    check("R4 evt none yet", evt_q, 32'd0);
    for (int k = 1; k <= 5; k++) begin
      step(1'b1);
      check("R4 stuck presc", presc_q, 32'd0);
      check("R4 evt each tick", evt_q, 32'(k));
    end
  endtask

  task automatic t_priority();
    load_all(32'd6, 32'd4, 32'd10);
    presc_ld = 1'b1; presc_ld_val = 32'd9;
    step(1'b1);
    check("R5 load beats dec", presc_q, 32'd9);
    check("R5 evt unchanged", evt_q, 32'd10);
    load_all(32'd6, 32'd0, 32'd10);
    presc_ld = 1'b1; presc_ld_val = 32'd3;
    step(1'b1);
    check("R5 load beats reload", presc_q, 32'd3);
    check("R5 evt still incs", evt_q, 32'd11);
    load_all(32'd6, 32'd0, 32'd10);
    evt_ld = 1'b1; evt_ld_val = 32'd77;
    step(1'b1);
    check("R6 load beats inc", evt_q, 32'd77);
    check("R6 presc reloaded", presc_q, 32'd6);
  endtask

  task automatic t_reload_change();
    load_all(32'd9, 32'd3, 32'd0);
    reload_ld = 1'b1; reload_ld_val = 32'd2;
    step(1'b0);
    check("R7 presc untouched", presc_q, 32'd3);
    check("R7 reload new", reload_q, 32'd2);
    for (int k = 0; k < 3; k++) step(1'b1);
    check("R7 at zero", presc_q, 32'd0);
    reload_ld = 1'b1; reload_ld_val = 32'd8;
    step(1'b1);   // reload uses value held before this edge
    check("R7 old reload used", presc_q, 32'd2);
    check("R7 reload now", reload_q, 32'd8);
  endtask

  task automatic t_wrap();
    load_all(32'd4, 32'd0, 32'hFFFF_FFFF);
    step(1'b1);
    check("R8 wrap evt", evt_q, 32'd0);
    check("R8 presc", presc_q, 32'd4);
    check("R8 reload", reload_q, 32'd4);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    check("R1 evt after reset", evt_q, 32'd0);
    check("R1 presc after reset", presc_q, 32'd0);
    t_reset();
    t_sequence();
    t_hold();
    t_zero_reload();
    t_priority();
    t_reload_change();
    t_wrap();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule